// File: doc/BRIEF.md
# Dual-Format Dirty-Metadata Controller for a Direct-Mapped DRAM Cache

This block is the controller for a direct-mapped DRAM cache of 64-byte lines that holds each line's metadata in two places. A line slot stores its tag, valid bit and dirty bit next to its payload, so one line access returns all of them. A separate grouped store packs the tags, valid bits and dirty bits of several neighbouring slots into one word, so one word read settles residency for the whole group. Requests come from the last-level cache (LLC) side, one per cycle. Each request is a read, a writeback or an install, and each gets a registered response one cycle later.

The controller decides which metadata accesses each request needs and reports them with the response. Every response also carries a dirtiness flag telling the LLC whether the DRAM copy is already marked dirty. When the LLC hands that flag back with a writeback, the grouped dirty update is skipped. A table of 2-bit saturating counters, indexed by a hash of the line address, guesses at install time whether the line will soon be written back. If it guesses yes, the line is marked dirty as it is installed.

The line payload is modelled as a `DATA_W`-bit word, and both stores behave as single-cycle memories. Addresses are line addresses: the byte offset is not part of them. Slot = low `log2(SETS)` bits; tag = the remaining upper bits; group = slot / `GROUP`.

Top module: `dmc_ctrl`

## Requirements
- R1: Reset leaves every slot invalid, gives no response and no eviction, and sets every predictor counter to 1. After reset, a single writeback hit on a hash index is therefore enough for an install on that index to be predicted dirty.
- R2: A read (op 0) always performs one grouped read. On a hit it also performs one line read and returns rsp_hit=1, the data, and rsp_dflag equal to the line's dirty bit. On a miss it returns rsp_hit=0 with no line access.
- R3: An install (op 2) performs a grouped read, a grouped write and a line write, with rsp_hit=0. A clean victim raises no eviction and decrements the predictor counter at the victim's hash index (saturating at 0).
- R4: An install whose victim slot holds a different dirty line also performs a line read. In the same response cycle it raises evict_valid with the victim's line address and data.
- R5: An install whose predictor counter is 2 or more sets both dirty bits of the new line and returns rsp_dflag=1. The hash index is addr[4:0] XOR addr[9:5] for the default 32-entry table.
- R6: A writeback (op 1) with req_dflag=0 that hits performs a grouped read, a grouped write and a line write. It sets both dirty bits, returns rsp_hit=1 and rsp_dflag=1, and increments the counter (saturating at 3).
- R7: A writeback with req_dflag=1 performs only a line write and no grouped access. It returns rsp_hit=1 and rsp_dflag=1, and increments the counter.
- R8: A writeback with req_dflag=0 that misses performs only a grouped read and changes no stored state. It forwards the request's address and data on the eviction output.
- R9: A grouped read-modify-write changes only the addressed member, so neighbouring slots in the same group keep their residency and dirty state.
- R10: The response for a request appears exactly one cycle after it. Back-to-back requests each see the stored effects of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 writeback, 2 install, 3 none |
| req_addr | input | ADDR_W | Line address |
| req_data | input | DATA_W | Writeback or install payload |
| req_dflag | input | 1 | Dirtiness flag held by the LLC for this line |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line resident (read/writeback) |
| rsp_dflag | output | 1 | DRAM copy marked dirty |
| rsp_data | output | DATA_W | Read hit data |
| rsp_grp_rd | output | 1 | Request read the grouped store |
| rsp_grp_wr | output | 1 | Request wrote the grouped store |
| rsp_line_rd | output | 1 | Request read a line slot |
| rsp_line_wr | output | 1 | Request wrote a line slot |
| evict_valid | output | 1 | Writeback to backing memory |
| evict_addr | output | ADDR_W | Line address of that writeback |
| evict_data | output | DATA_W | Payload of that writeback |

## Verification
Two functions can fall in the same cycle: the eviction of a dirty victim, and the predicted-dirty marking of the line that replaces it. The bench provokes this by training a predictor index to saturation with writeback hits. It then installs an address with that hash into a slot whose line was made dirty just before. The response is judged on all of the following at once: the eviction address and data match the old line, rsp_dflag reports the new line dirty, all four access flags are set, and a later read shows the new line with its dirty bit set.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      OP_READ = 2'd0,
      OP_WB   = 2'd1,
      OP_INST = 2'd2,
      OP_NONE = 2'd3
   } dmc_op_e;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
   parameter int SETS   = 64,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 64,
   localparam int IW    = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IW-1:0]     rd_idx,
   output logic              rd_vld,
   output logic              rd_dty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              we,
   input  logic [IW-1:0]     wr_idx,
   input  logic              wr_dty,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   logic [SETS-1:0]   vld_q, dty_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         dty_q <= '0;
      end else if (we) begin
         vld_q[wr_idx] <= 1'b1;
         dty_q[wr_idx] <= wr_dty;
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_vld  = vld_q[rd_idx];
   assign rd_dty  = dty_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
   assign rd_data = data_q[rd_idx];

   // R10: a line write is visible from the next cycle
   a_r10_line_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (vld_q[$past(wr_idx)] && dty_q[$past(wr_idx)] == $past(wr_dty)));
endmodule

// File: rtl/dmc_group_store.sv
module dmc_group_store #(
   parameter int GROUPS = 16,
   parameter int GROUP  = 4,
   parameter int TAG_W  = 6,
   localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [GW-1:0]          idx,
   output logic [GROUP*TAG_W-1:0] rd_tags,
   output logic [GROUP-1:0]       rd_vld,
   output logic [GROUP-1:0]       rd_dty,
   input  logic                   we,
   input  logic [GROUP*TAG_W-1:0] wr_tags,
   input  logic [GROUP-1:0]       wr_vld,
   input  logic [GROUP-1:0]       wr_dty
);
   logic [GROUP*TAG_W-1:0] tags_q [GROUPS];
   logic [GROUP-1:0]       vld_q  [GROUPS];
   logic [GROUP-1:0]       dty_q  [GROUPS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < GROUPS; g++) begin
            vld_q[g] <= '0;
            dty_q[g] <= '0;
         end
      end else if (we) begin
         vld_q[idx] <= wr_vld;
         dty_q[idx] <= wr_dty;
      end
   end

   always_ff @(posedge clk) begin
      if (we) tags_q[idx] <= wr_tags;
   end

   assign rd_tags = tags_q[idx];
   assign rd_vld  = vld_q[idx];
   assign rd_dty  = dty_q[idx];

   // R9: the whole grouped word lands as written
   a_r9_group_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (vld_q[$past(idx)] == $past(wr_vld) && dty_q[$past(idx)] == $past(wr_dty)));
endmodule

// File: rtl/dmc_pred.sv
module dmc_pred #(
   parameter int ENTRIES = 32,
   localparam int IW     = $clog2(ENTRIES),
   localparam int SRC_W  = 2 * IW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] look_addr,
   output logic             predict,
   input  logic             inc_en,
   input  logic [SRC_W-1:0] inc_addr,
   input  logic             dec_en,
   input  logic [SRC_W-1:0] dec_addr
);
   logic [2*ENTRIES-1:0] cnt_q;
   logic [IW-1:0]        look_i, inc_i, dec_i;

   function automatic logic [IW-1:0] fold(input logic [SRC_W-1:0] a);
      return a[IW-1:0] ^ a[SRC_W-1:IW];
   endfunction

   assign look_i  = fold(look_addr);
   assign inc_i   = fold(inc_addr);
   assign dec_i   = fold(dec_addr);
   assign predict = cnt_q[2*look_i+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= {ENTRIES{2'b01}};
      end else begin
         if (inc_en && cnt_q[2*inc_i +: 2] != 2'd3)
            cnt_q[2*inc_i +: 2] <= cnt_q[2*inc_i +: 2] + 2'd1;
         if (dec_en && cnt_q[2*dec_i +: 2] != 2'd0)
            cnt_q[2*dec_i +: 2] <= cnt_q[2*dec_i +: 2] - 2'd1;
      end
   end

   // R3: counters change only on a training event
   a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_en && !dec_en) |=> $stable(cnt_q));
   // R6: an unsaturated counter steps up by one on a writeback hit
   a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !dec_en && cnt_q[2*inc_i +: 2] != 2'd3)
      |=> cnt_q[2*$past(inc_i) +: 2] == $past(cnt_q[2*inc_i +: 2]) + 2'd1);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl #(
   parameter int ADDR_W       = 12,
   parameter int SETS         = 64,
   parameter int GROUP        = 4,
   parameter int DATA_W       = 64,
   parameter int PRED_ENTRIES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_dflag,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_dflag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_grp_rd,
   output logic              rsp_grp_wr,
   output logic              rsp_line_rd,
   output logic              rsp_line_wr,
   output logic              evict_valid,
   output logic [ADDR_W-1:0] evict_addr,
   output logic [DATA_W-1:0] evict_data
);
   import dmc_pkg::*;

   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W;
   localparam int GSH    = $clog2(GROUP);
   localparam int GROUPS = SETS / GROUP;
   localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
   localparam int PW     = 2 * $clog2(PRED_ENTRIES);

   generate
      if (SETS != (1 << IDX_W)) begin : g_bad_sets
         $error("SETS must be a power of two");
      end
      if (GROUP < 2 || GROUP != (1 << GSH) || GROUP >= SETS) begin : g_bad_group
         $error("GROUP must be a power of two, at least 2, below SETS");
      end
      if (TAG_W < 1 || ADDR_W < PW) begin : g_bad_addr
         $error("ADDR_W too narrow for SETS or PRED_ENTRIES");
      end
   endgenerate

   dmc_op_e            op;
   logic [IDX_W-1:0]   slot;
   logic [TAG_W-1:0]   tag;
   logic [GW-1:0]      gidx;
   logic [GSH-1:0]     mem;

   assign op   = req_valid ? dmc_op_e'(req_op) : OP_NONE;
   assign slot = req_addr[IDX_W-1:0];
   assign tag  = req_addr[ADDR_W-1:IDX_W];
   assign mem  = slot[GSH-1:0];
   generate
      if (GROUPS > 1) begin : g_gidx
         assign gidx = slot[IDX_W-1:GSH];
      end else begin : g_gidx1
         assign gidx = 1'b0;
      end
   endgenerate

   // grouped store
   logic [GROUP*TAG_W-1:0] g_tags, n_tags;
   logic [GROUP-1:0]       g_vld, g_dty, n_vld, n_dty;
   logic                   grp_we;
   logic [TAG_W-1:0]       m_tag;
   logic                   m_vld, m_dty, g_hit;

   dmc_group_store #(.GROUPS(GROUPS), .GROUP(GROUP), .TAG_W(TAG_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .idx(gidx),
      .rd_tags(g_tags), .rd_vld(g_vld), .rd_dty(g_dty),
      .we(grp_we), .wr_tags(n_tags), .wr_vld(n_vld), .wr_dty(n_dty));

   assign m_tag = g_tags[mem*TAG_W +: TAG_W];
   assign m_vld = g_vld[mem];
   assign m_dty = g_dty[mem];
   assign g_hit = m_vld && (m_tag == tag);

   // line store
   logic              l_vld, l_dty, line_we, lw_dty;
   logic [TAG_W-1:0]  l_tag;
   logic [DATA_W-1:0] l_data;

   dmc_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_line (
      .clk(clk), .rst_n(rst_n), .rd_idx(slot),
      .rd_vld(l_vld), .rd_dty(l_dty), .rd_tag(l_tag), .rd_data(l_data),
      .we(line_we), .wr_idx(slot), .wr_dty(lw_dty), .wr_tag(tag), .wr_data(req_data));

   // predictor
   logic              predict, p_inc, p_dec;
   logic [ADDR_W-1:0] victim_addr;

   assign victim_addr = {m_tag, slot};

   dmc_pred #(.ENTRIES(PRED_ENTRIES)) u_pred (
      .clk(clk), .rst_n(rst_n),
      .look_addr(req_addr[PW-1:0]), .predict(predict),
      .inc_en(p_inc), .inc_addr(req_addr[PW-1:0]),
      .dec_en(p_dec), .dec_addr(victim_addr[PW-1:0]));

   // request decode
   logic              c_valid, c_hit, c_dflag, c_grd, c_lrd, c_ev;
   logic [DATA_W-1:0] c_data, c_edata;
   logic [ADDR_W-1:0] c_eaddr;
   logic              u_tag_wr, u_dty;
   logic              victim;

   assign victim = m_vld && (m_tag != tag);

   always_comb begin
      c_valid  = (op != OP_NONE);
      c_hit    = 1'b0;
      c_dflag  = 1'b0;
      c_data   = '0;
      c_grd    = 1'b0;
      c_lrd    = 1'b0;
      c_ev     = 1'b0;
      c_eaddr  = '0;
      c_edata  = '0;
      grp_we   = 1'b0;
      line_we  = 1'b0;
      lw_dty   = 1'b0;
      u_tag_wr = 1'b0;
      u_dty    = 1'b0;
      p_inc    = 1'b0;
      p_dec    = 1'b0;
      unique case (op)
         OP_READ: begin
            c_grd = 1'b1;
            if (g_hit) begin
               c_lrd   = 1'b1;
               c_hit   = 1'b1;
               c_dflag = l_dty;
               c_data  = l_data;
            end
         end
         OP_WB: begin
            if (req_dflag) begin
               line_we = 1'b1;
               lw_dty  = 1'b1;
               c_hit   = 1'b1;
               c_dflag = 1'b1;
               p_inc   = 1'b1;
            end else begin
               c_grd = 1'b1;
               if (g_hit) begin
                  grp_we  = 1'b1;
                  u_dty   = 1'b1;
                  line_we = 1'b1;
                  lw_dty  = 1'b1;
                  c_hit   = 1'b1;
                  c_dflag = 1'b1;
                  p_inc   = 1'b1;
               end else begin
                  c_ev    = 1'b1;
                  c_eaddr = req_addr;
                  c_edata = req_data;
               end
            end
         end
         OP_INST: begin
            c_grd    = 1'b1;
            grp_we   = 1'b1;
            line_we  = 1'b1;
            u_tag_wr = 1'b1;
            u_dty    = predict;
            lw_dty   = predict;
            c_dflag  = predict;
            if (victim && m_dty) begin
               c_lrd   = 1'b1;
               c_ev    = 1'b1;
               c_eaddr = victim_addr;
               c_edata = l_data;
            end
            if (victim && !m_dty) p_dec = 1'b1;
         end
         default: ;
      endcase
   end

   // grouped word merge: only the addressed member changes
   generate
      for (genvar m = 0; m < GROUP; m++) begin : g_merge
         logic sel;
         assign sel = (mem == GSH'(m));
         assign n_tags[m*TAG_W +: TAG_W] = (sel && u_tag_wr) ? tag : g_tags[m*TAG_W +: TAG_W];
         assign n_vld[m] = (sel && u_tag_wr) ? 1'b1 : g_vld[m];
         assign n_dty[m] = sel ? u_dty : g_dty[m];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_dflag   <= 1'b0;
         rsp_data    <= '0;
         rsp_grp_rd  <= 1'b0;
         rsp_grp_wr  <= 1'b0;
         rsp_line_rd <= 1'b0;
         rsp_line_wr <= 1'b0;
         evict_valid <= 1'b0;
         evict_addr  <= '0;
         evict_data  <= '0;
      end else begin
         rsp_valid   <= c_valid;
         rsp_hit     <= c_hit;
         rsp_dflag   <= c_dflag;
         rsp_data    <= c_data;
         rsp_grp_rd  <= c_grd;
         rsp_grp_wr  <= grp_we;
         rsp_line_rd <= c_lrd;
         rsp_line_wr <= line_we;
         evict_valid <= c_ev;
         evict_addr  <= c_eaddr;
         evict_data  <= c_edata;
      end
   end

   // R7: a writeback carrying the flag never touches the grouped store
   a_r7_pruned_no_group: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd1 && req_dflag) |-> !grp_we);
   // R2: the two metadata copies agree whenever the grouped store reports residency
   a_r2_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ && g_hit) |-> (l_vld && l_tag == tag));
   // R4: an eviction is always part of a response
   a_r4_evict_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> rsp_valid);
   // R10: every response follows a request one cycle earlier
   a_r10_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));
endmodule

// File: tb/dmc_ctrl_test.sv
module dmc_ctrl_test;
   localparam int CLK_P = 10;
   localparam int NV    = 24;

   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] addr;
      logic [63:0] data;
      logic        flag;
      logic        ehit;
      logic        edf;
      logic [63:0] erd;
      logic [3:0]  eacc;   // {grp_rd, grp_wr, line_rd, line_wr}
      logic        eev;
      logic [11:0] eea;
      logic [63:0] eed;
   } vec_t;

   // op: 0 read, 1 writeback, 2 install
   localparam vec_t VT [NV] = '{
      '{2'd0, 12'h005, 64'h0,    1'b0, 1'b0, 1'b0, 64'h0,    4'b1000, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h005, 64'h1001, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd0, 12'h005, 64'h0,    1'b0, 1'b1, 1'b0, 64'h1001, 4'b1010, 1'b0, 12'h000, 64'h0},
      '{2'd1, 12'h005, 64'h1002, 1'b0, 1'b1, 1'b1, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd1, 12'h005, 64'h1003, 1'b1, 1'b1, 1'b1, 64'h0,    4'b0001, 1'b0, 12'h000, 64'h0},
      '{2'd0, 12'h005, 64'h0,    1'b0, 1'b1, 1'b1, 64'h1003, 4'b1010, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h045, 64'h1004, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1111, 1'b1, 12'h005, 64'h1003},
      '{2'd0, 12'h005, 64'h0,    1'b0, 1'b0, 1'b0, 64'h0,    4'b1000, 1'b0, 12'h000, 64'h0},
      '{2'd0, 12'h045, 64'h0,    1'b0, 1'b1, 1'b0, 64'h1004, 4'b1010, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h085, 64'h1005, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd1, 12'h0A5, 64'h1006, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1000, 1'b1, 12'h0A5, 64'h1006},
      '{2'd1, 12'h085, 64'h1007, 1'b0, 1'b1, 1'b1, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h405, 64'h1008, 1'b0, 1'b0, 1'b1, 64'h0,    4'b1111, 1'b1, 12'h085, 64'h1007},
      '{2'd0, 12'h405, 64'h0,    1'b0, 1'b1, 1'b1, 64'h1008, 4'b1010, 1'b0, 12'h000, 64'h0},
      '{2'd1, 12'h405, 64'h1009, 1'b1, 1'b1, 1'b1, 64'h0,    4'b0001, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h805, 64'h100A, 1'b0, 1'b0, 1'b1, 64'h0,    4'b1111, 1'b1, 12'h405, 64'h1009},
      '{2'd2, 12'h004, 64'h100B, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd0, 12'h805, 64'h0,    1'b0, 1'b1, 1'b1, 64'h100A, 4'b1010, 1'b0, 12'h000, 64'h0},
      '{2'd0, 12'h004, 64'h0,    1'b0, 1'b1, 1'b0, 64'h100B, 4'b1010, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h046, 64'h100C, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd1, 12'h046, 64'h100D, 1'b0, 1'b1, 1'b1, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h044, 64'h100E, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h067, 64'h100F, 1'b0, 1'b0, 1'b0, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0},
      '{2'd2, 12'h0A4, 64'h1010, 1'b0, 1'b0, 1'b1, 64'h0,    4'b1101, 1'b0, 12'h000, 64'h0}
   };

   // requirement checked by each vector
   localparam string TAG [NV] = '{
      "R2", "R3", "R2", "R6", "R7", "R10", "R4", "R2", "R2", "R3", "R8", "R6",
      "R5", "R5", "R7", "R5", "R9", "R9", "R9", "R3", "R6", "R3", "R3", "R1"
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd3;
   logic [11:0] req_addr = '0;
   logic [63:0] req_data = '0;
   logic        req_dflag = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_dflag;
   logic [63:0] rsp_data;
   logic        rsp_grp_rd, rsp_grp_wr, rsp_line_rd, rsp_line_wr;
   logic        evict_valid;
   logic [11:0] evict_addr;
   logic [63:0] evict_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dmc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .req_dflag(req_dflag),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dflag(rsp_dflag),
      .rsp_data(rsp_data), .rsp_grp_rd(rsp_grp_rd), .rsp_grp_wr(rsp_grp_wr),
      .rsp_line_rd(rsp_line_rd), .rsp_line_wr(rsp_line_wr),
      .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data));

   task automatic drive(input logic [1:0] op, input logic [11:0] a,
                        input logic [63:0] d, input logic f);
      req_valid = 1'b1;
      req_op    = op;
      req_addr  = a;
      req_data  = d;
      req_dflag = f;
   endtask

   task automatic idle();
      req_valid = 1'b0;
      req_op    = 2'd3;
      req_dflag = 1'b0;
   endtask

   task automatic check_vec(input vec_t v, input string tg, input int i);
      logic [3:0] acc;
      bit bad;
      acc = {rsp_grp_rd, rsp_grp_wr, rsp_line_rd, rsp_line_wr};
      bad = !rsp_valid || rsp_hit !== v.ehit || rsp_dflag !== v.edf ||
            acc !== v.eacc || evict_valid !== v.eev;
      if (v.op == 2'd0 && v.ehit && rsp_data !== v.erd) bad = 1'b1;
      if (v.eev && (evict_addr !== v.eea || evict_data !== v.eed)) bad = 1'b1;
      n_chk++;
      if (bad) begin
         n_bad++;
         $display("FAIL %s vec %0d: got v%b h%b df%b d%h acc%b ev%b %h %h exp h%b df%b d%h acc%b ev%b %h %h",
                  tg, i, rsp_valid, rsp_hit, rsp_dflag, rsp_data, acc, evict_valid,
                  evict_addr, evict_data, v.ehit, v.edf, v.erd, v.eacc, v.eev, v.eea, v.eed);
      end
   endtask

   initial begin
      #(CLK_P * 2000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      n_chk++;
      if (rsp_valid !== 1'b0 || evict_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: got rsp %b ev %b exp 0 0", rsp_valid, evict_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VT[i].op, VT[i].addr, VT[i].data, VT[i].flag);
         @(negedge clk);
         check_vec(VT[i], TAG[i], i);
      end

      // R10: no request, no response
      idle();
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0 || evict_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 idle: got rsp %b ev %b exp 0 0", rsp_valid, evict_valid);
      end

      // R1: reset mid-run invalidates resident lines
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      drive(2'd0, 12'h805, 64'h0, 1'b0);
      @(negedge clk);
      check_vec('{2'd0, 12'h805, 64'h0, 1'b0, 1'b0, 1'b0, 64'h0, 4'b1000,
                  1'b0, 12'h000, 64'h0}, "R1", NV);
      idle();
      @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule